// File: doc/BRIEF.md
# Page Write Buffer and Self-Timed Programming Controller

This block sits behind the command decoder of a serial memory. During a write command it collects data bytes into a page buffer whose size is a parameter (32 bytes by default). The page is taken from the first byte that is stored. Later bytes land in that page at the column given by their low address bits. When chip select returns high after at least one byte has been stored, the block starts a self-timed programming cycle. The cycle copies every stored byte into the array and holds a busy flag for a fixed number of clocks.

No erase step comes before programming. Each stored location is simply overwritten. A falling write-protect pin, or an abort from the decoder, throws away a command that is still being entered. Once the cycle has started, the write-protect pin has no effect on it. While busy, the block ignores incoming bytes. The decoder uses the busy flag to reject array and status writes and to keep reporting "not ready". A one-clock done pulse at the end of the cycle lets the write-enable latch clear.

Top module: `page_prog_ctrl`

## Requirements
- R1: After reset, `busy`, `cycle_done` and `arr_we` are all 0.
- R2: A programming cycle starts only on a clock where `cs_n` is sampled high after having been low, and only if the command stored at least one byte. `busy` is 1 from the next clock for exactly CYCLE_CLKS clocks.
- R3: `cycle_done` is 1 for exactly one clock: the first clock in which `busy` is 0 again after a cycle.
- R4: The page number (`byte_addr[ADDR_W-1:5]` with the default 32-byte page) is taken from the first stored byte of a command. Every later byte goes to column `byte_addr[4:0]` of that same page, and its upper address bits are ignored, so a run past column 31 wraps to column 0 of the page.
- R5: A later byte to an already loaded column replaces the earlier one. During the cycle, only loaded columns are written, one per clock, in ascending column order, within the first PAGE_BYTES clocks of `busy`. `arr_addr` is {page, column}.
- R6: A byte presented with `byte_permit` = 0 is not stored.
- R7: A falling edge of `wp_n` while `cs_n` is low discards all bytes of the command in progress and every later byte of it; no cycle follows.
- R8: Changes of `wp_n` while `busy` is 1 do not shorten the cycle or suppress any array write.
- R9: Bytes presented while `busy` is 1 are ignored, and so is the remainder of the same command, even after `busy` falls.
- R10: `cmd_abort` = 1 while `cs_n` is low discards the command in progress like R7.
- R11: A `cs_n` rise with no stored byte starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select level, low while a command is in progress |
| wp_n | input | 1 | Write-protect pin level, active low |
| byte_vld | input | 1 | One-clock strobe for a write data byte |
| byte_addr | input | ADDR_W | Array address of the strobed byte |
| byte_data | input | DATA_W | Strobed data byte |
| byte_permit | input | 1 | Protection unit allows this byte |
| cmd_abort | input | 1 | Decoder cancels the command in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | DATA_W | Array write data |
| busy | output | 1 | Programming cycle in progress |
| cycle_done | output | 1 | One-clock pulse at the end of the cycle |

## Verification
The properties assume that all inputs are synchronous to `clk`. They also assume that `byte_vld` is only raised while `cs_n` is low, and that CYCLE_CLKS is at least PAGE_BYTES, so the drain of the buffer fits inside the cycle. The stimulus changes inputs only on the falling clock edge. It gives each byte a single-clock strobe followed by an idle clock, always frames bytes inside a low `cs_n`, and keeps the default cycle length of 48 clocks against the 32-byte page.

// File: rtl/pwc_pkg.sv
`timescale 1ns/1ps
// Shared types for the page programming controller.
package pwc_pkg;
    // Controller phase: no data, collecting a command, programming.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } pwc_phase_e;
endpackage

// File: rtl/pwc_page_buf.sv
`timescale 1ns/1ps
// Page buffer: one data register and one loaded flag per column.
// Assumes wr_en and clr are never used for the same column with
// conflicting intent; clr wins over a write in the same clock.
module pwc_page_buf #(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 32,
    parameter int COL_W      = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [COL_W-1:0]  rd_col,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_vld
);
    logic [DATA_W-1:0] data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_col
        // Store a byte into this column and mark it loaded.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[g] <= '0;
                vld_q[g]  <= 1'b0;
            end else if (clr) begin
                vld_q[g]  <= 1'b0;
            end else if (wr_en && wr_col == COL_W'(g)) begin
                data_q[g] <= wr_data;
                vld_q[g]  <= 1'b1;
            end
        end
    end

    // Read port used by the drain during the programming cycle.
    always_comb begin
        rd_data = data_q[rd_col];
        rd_vld  = vld_q[rd_col];
    end
endmodule

// File: rtl/pwc_cycle_timer.sv
`timescale 1ns/1ps
// Self-timed cycle counter: runs for CYCLE_CLKS clocks after start.
// Assumes start is only raised while the timer is not running.
module pwc_cycle_timer #(
    parameter int CYCLE_CLKS = 48,
    parameter int CNT_W      = $clog2(CYCLE_CLKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic last
);
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    // Load the count on start, count down to zero, then stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= CNT_W'(CYCLE_CLKS - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    // Final clock of the cycle.
    always_comb last = run_q && (cnt_q == '0);
endmodule

// File: rtl/page_prog_ctrl.sv
`timescale 1ns/1ps
// Page write collector and self-timed programming controller.
// Collects strobed bytes of a write command into a page buffer and
// commits them on the rising edge of cs_n, then drains loaded columns
// to the array while busy is held for CYCLE_CLKS clocks.
// Assumes: inputs synchronous to clk, byte_vld only while cs_n is low,
// PAGE_BYTES a power of two, CYCLE_CLKS >= PAGE_BYTES.
module page_prog_ctrl
    import pwc_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 32,
    parameter int CYCLE_CLKS = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wp_n,
    input  logic              byte_vld,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              byte_permit,
    input  logic              cmd_abort,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data,
    output logic              busy,
    output logic              cycle_done
);
    localparam int COL_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ADDR_W - COL_W;

    pwc_phase_e        phase_q;
    logic              cs_n_q, wp_n_q, drop_q, done_q;
    logic [PG_W-1:0]   page_q;
    logic [COL_W:0]    ptr_q;
    logic              cs_rise, wp_fall, kill, store, start, tmr_last, clr;
    logic [DATA_W-1:0] rd_data;
    logic              rd_vld;

    // Edge detection on chip select and write protect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_q <= 1'b1;
            wp_n_q <= 1'b1;
        end else begin
            cs_n_q <= cs_n;
            wp_n_q <= wp_n;
        end
    end

    // Command-level decisions for this clock.
    always_comb begin
        busy    = (phase_q == PH_PROG);
        cs_rise = !cs_n_q && cs_n;
        wp_fall = wp_n_q && !wp_n;
        kill    = !cs_n && !busy && (wp_fall || cmd_abort);
        store   = byte_vld && byte_permit && !cs_n && !busy && !drop_q && !kill;
        start   = (phase_q == PH_LOAD) && cs_rise;
        clr     = ((phase_q == PH_LOAD) && kill) || tmr_last;
    end

    // Drop flag: rest of the current command is ignored.
    always_ff @(posedge clk) begin
        if (!rst_n)                       drop_q <= 1'b0;
        else if (cs_n)                    drop_q <= 1'b0;
        else if (kill || (byte_vld && busy)) drop_q <= 1'b1;
    end

    // Phase sequencing: collect, program, return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (store)    phase_q <= PH_LOAD;
                PH_LOAD: if (kill)     phase_q <= PH_IDLE;
                         else if (start) phase_q <= PH_PROG;
                PH_PROG: if (tmr_last) phase_q <= PH_IDLE;
                default:               phase_q <= PH_IDLE;
            endcase
        end
    end

    // Page number latched from the first stored byte of a command.
    always_ff @(posedge clk) begin
        if (!rst_n)                             page_q <= '0;
        else if (store && phase_q == PH_IDLE)   page_q <= byte_addr[ADDR_W-1:COL_W];
    end

    // Drain pointer walks the columns once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ptr_q <= '0;
        else if (start)                ptr_q <= '0;
        else if (busy && !ptr_q[COL_W]) ptr_q <= ptr_q + 1'b1;
    end

    // End-of-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= tmr_last;
    end

    pwc_page_buf #(
        .DATA_W     (DATA_W),
        .PAGE_BYTES (PAGE_BYTES),
        .COL_W      (COL_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store),
        .wr_col  (byte_addr[COL_W-1:0]),
        .wr_data (byte_data),
        .clr     (clr),
        .rd_col  (ptr_q[COL_W-1:0]),
        .rd_data (rd_data),
        .rd_vld  (rd_vld)
    );

    pwc_cycle_timer #(
        .CYCLE_CLKS (CYCLE_CLKS)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .last  (tmr_last)
    );

    // Array write port driven from the drain pointer.
    always_comb begin
        arr_we     = busy && !ptr_q[COL_W] && rd_vld;
        arr_addr   = {page_q, ptr_q[COL_W-1:0]};
        arr_data   = rd_data;
        cycle_done = done_q;
    end
endmodule

// File: rtl/pwc_checker.sv
`timescale 1ns/1ps
// Property checker for page_prog_ctrl, attached by bind below.
// Assumes CYCLE_CLKS >= PAGE_BYTES and inputs synchronous to clk.
module pwc_checker #(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 32,
    parameter int CYCLE_CLKS = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              busy,
    input logic              cycle_done
);
    localparam int COL_W = $clog2(PAGE_BYTES);

    logic [31:0] blen;

    // Counts clocks of the current busy interval.
    always_ff @(posedge clk) begin
        if (!rst_n)    blen <= '0;
        else if (busy) blen <= blen + 1;
        else           blen <= '0;
    end

    p_start_on_cs_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_n));

    p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (blen == 32'(CYCLE_CLKS)));

    p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> (!busy && $past(busy)));

    p_done_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> cycle_done);

    p_we_only_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    p_we_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (blen < 32'(PAGE_BYTES)));

    p_same_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && busy && $past(arr_we) && $past(busy)) |->
        (arr_addr[ADDR_W-1:COL_W] == $past(arr_addr[ADDR_W-1:COL_W])));

    p_col_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && busy && $past(arr_we) && $past(busy)) |->
        (arr_addr[COL_W-1:0] > $past(arr_addr[COL_W-1:0])));
endmodule

bind page_prog_ctrl pwc_checker #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .CYCLE_CLKS (CYCLE_CLKS)
) u_pwc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .arr_we     (arr_we),
    .arr_addr   (arr_addr),
    .busy       (busy),
    .cycle_done (cycle_done)
);

// File: tb/tb_page_prog_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: command tasks push expected array writes, the
// monitor pops and compares them as the design drains its buffer.
module tb_page_prog_ctrl;
    localparam int AW  = 11;
    localparam int DW  = 8;
    localparam int PB  = 32;
    localparam int CYC = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, wp_n = 1'b1, byte_vld = 1'b0;
    logic [AW-1:0] byte_addr = '0;
    logic [DW-1:0] byte_data = '0;
    logic          byte_permit = 1'b1, cmd_abort = 1'b0;
    logic          arr_we, busy, cycle_done;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_data;

    always #4 clk = ~clk;

    page_prog_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .CYCLE_CLKS(CYC)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .byte_vld(byte_vld),
        .byte_addr(byte_addr), .byte_data(byte_data), .byte_permit(byte_permit),
        .cmd_abort(cmd_abort), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_data(arr_data), .busy(busy), .cycle_done(cycle_done));

    int errors = 0, checks = 0;
    logic [AW+DW-1:0] exp_q[$];
    int exp_cycles = 0, mon_cycles = 0;

    // Bench model of the command being entered.
    logic          m_have, m_drop;
    logic [AW-6:0] m_page;
    logic          m_vld [PB];
    logic [DW-1:0] m_dat [PB];

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic m_clear();
        m_have = 1'b0;
        for (int i = 0; i < PB; i++) m_vld[i] = 1'b0;
    endtask

    task automatic cmd_begin();
        @(negedge clk);
        cs_n = 1'b0;
        m_drop = 1'b0;
        m_clear();
    endtask

    task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic p);
        @(negedge clk);
        byte_vld = 1'b1; byte_addr = a; byte_data = d; byte_permit = p;
        if (busy) m_drop = 1'b1;
        if (!m_drop && p) begin
            if (!m_have) m_page = a[AW-1:5];
            m_have = 1'b1;
            m_vld[a[4:0]] = 1'b1;
            m_dat[a[4:0]] = d;
        end
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic kill_cmd(input logic use_wp);
        @(negedge clk);
        if (use_wp) wp_n = 1'b0; else cmd_abort = 1'b1;
        m_drop = 1'b1;
        m_clear();
        @(negedge clk);
        wp_n = 1'b1; cmd_abort = 1'b0;
    endtask

    // Ends the command; pushes expected writes if a cycle should start.
    task automatic cmd_end(input string req);
        logic go;
        @(negedge clk);
        cs_n = 1'b1;
        go = m_have && !m_drop;
        if (go) begin
            exp_cycles++;
            for (int c = 0; c < PB; c++)
                if (m_vld[c]) exp_q.push_back({m_page, 5'(c), m_dat[c]});
        end
        @(negedge clk);
        chk(busy == go, req, int'(busy), int'(go));
    endtask

    task automatic wait_idle(input string req);
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
        chk(mon_cycles == exp_cycles, req, mon_cycles, exp_cycles);
    endtask

    // Monitor: compares array writes and busy/done timing.
    logic prev_busy = 1'b0;
    int   blen = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (arr_we) begin
                if (exp_q.size() == 0) chk(1'b0, "R5 unexpected write", int'(arr_addr), 0);
                else begin
                    logic [AW+DW-1:0] e;
                    e = exp_q.pop_front();
                    chk({arr_addr, arr_data} == e, "R4/R5 write", int'({arr_addr, arr_data}), int'(e));
                end
            end
            if (busy && !prev_busy) mon_cycles++;
            if (busy) blen++;
            if (!busy && prev_busy) begin
                chk(blen == CYC, "R2 busy length", blen, CYC);
                chk(cycle_done == 1'b1, "R3 done pulse", int'(cycle_done), 1);
                blen = 0;
            end else if (cycle_done) begin
                chk(1'b0, "R3 stray done", 1, 0);
            end
            prev_busy = busy;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_drop = 1'b0; m_page = '0; m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(cycle_done == 1'b0, "R1 done", int'(cycle_done), 0);
        chk(arr_we == 1'b0, "R1 we", int'(arr_we), 0);

        // R2: single byte write
        cmd_begin(); put(11'h123, 8'h5A, 1'b1); cmd_end("R2 start");
        wait_idle("R2 single");

        // R4/R5: 35 bytes from column 30, some upper bits changed, wrap and overwrite
        cmd_begin();
        for (int i = 0; i < 35; i++) begin
            logic [5:0] pg;
            pg = (i % 3 == 1) ? 6'h2A : 6'h15;
            put({pg, 5'((30 + i) % 32)}, 8'(8'h30 + i), 1'b1);
        end
        cmd_end("R4 start");
        wait_idle("R4 wrap");

        // R6: alternate bytes without permit
        cmd_begin();
        for (int i = 0; i < 8; i++) put({6'h07, 5'(4 + i)}, 8'(8'hC0 ^ i), (i % 2) == 0);
        cmd_end("R6 start");
        wait_idle("R6 permit");

        // R7: write-protect fall during entry discards the command
        cmd_begin();
        put(11'h040, 8'h11, 1'b1); put(11'h041, 8'h22, 1'b1);
        kill_cmd(1'b1);
        put(11'h042, 8'h33, 1'b1);
        cmd_end("R7 no start");
        wait_idle("R7 wp");

        // R10: decoder abort discards the command
        cmd_begin(); put(11'h080, 8'h44, 1'b1); kill_cmd(1'b0); put(11'h081, 8'h55, 1'b1);
        cmd_end("R10 no start");
        wait_idle("R10 abort");

        // R11: select/deselect with no byte
        cmd_begin(); cmd_end("R11 no start");
        wait_idle("R11 empty");

        // R8: wp toggles during the cycle have no effect
        cmd_begin();
        for (int i = 0; i < 4; i++) put({6'h3F, 5'(28 + i)}, 8'(8'h90 + i), 1'b1);
        cmd_end("R8 start");
        repeat (5) @(negedge clk);
        wp_n = 1'b0; repeat (3) @(negedge clk); wp_n = 1'b1;
        @(negedge clk); wp_n = 1'b0; @(negedge clk); wp_n = 1'b1;
        wait_idle("R8 wp busy");

        // R9: command during busy, continuing after busy falls, is ignored
        cmd_begin(); put(11'h200, 8'hA5, 1'b1); cmd_end("R9 first start");
        repeat (2) @(negedge clk);
        cmd_begin();
        put(11'h300, 8'h66, 1'b1);
        while (busy) @(negedge clk);
        put(11'h301, 8'h77, 1'b1);
        @(negedge clk); cs_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R9 no second cycle", int'(busy), 0);
        wait_idle("R9 busy reject");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule